// File: doc/BRIEF.md
# Phased Instruction Sequencer

This block is a small stored-program processor core with 16-bit words. Every instruction it runs walks through a fixed chain of named phases: fetch, decode, evaluate address, fetch operands, execute and store result. Instructions and data share one word-addressed memory. The core reaches that memory only through its memory address register and its memory data register. The address output always shows the address register, and the write-data output always shows the data register.

The core holds eight general-purpose registers. It executes four instruction kinds:

- a register add;
- a base-plus-offset load;
- a base-plus-offset store;
- an unconditional PC-relative branch.

It also has a halt code. Every other opcode is a no-op that still takes all the phases. A debug view shows the program counter and all eight registers, so a test program can be followed from outside the core. The core is meant to sit next to a single-port synchronous memory whose read data arrives one cycle after the address.

Top module: `seqcpu_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core sets the PC to 0, clears all eight registers and drops `halted`. The first fetch after reset presents address 0 on `mem_addr`.
- R2: The cycle counts are fixed. A load takes 11 clock cycles from the start of its fetch to the start of the next fetch. Every other instruction takes 9 cycles. Within each instruction, the phases run in the fixed order fetch, decode, evaluate address, fetch operands, execute, store result.
- R3: The first fetch cycle copies the PC into the address register and adds 1 to the PC. Without a taken branch, instructions run from consecutive addresses.
- R4: The add has opcode 0001, with destination in bits [11:9], first source in [8:6] and second source in [2:0]. It writes the sum of the two sources, modulo 2^16, into the destination register.
- R5: The load has opcode 0110, with destination in [11:9], base register in [8:6] and a signed offset in [5:0]. It writes into the destination the memory word at the base value plus the sign-extended offset.
- R6: The store has opcode 0111, with source in [11:9], base in [8:6] and a signed offset in [5:0]. It makes exactly one memory write, of the source value, to the base value plus the sign-extended offset. No other instruction asserts `mem_we`.
- R7: The branch has opcode 0000. It sets the PC to the address of the branch plus one plus the sign-extended offset in [11:0]. Both forward and backward targets work.
- R8: Opcode 1111 halts the core. After its last phase, `halted` stays high, the PC and the registers stay unchanged, and no memory write occurs.
- R9: Any other opcode changes no register and writes no memory. It still takes 9 cycles.
- R10: `dbg_regs` carries register n in bits [16n+15:16n], and `dbg_pc` carries the program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory address, always the address register |
| mem_wdata | output | 16 | Memory write data, always the data register |
| mem_we | output | 1 | Memory write enable, high during a store's execute cycle |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has completed |
| dbg_pc | output | 16 | Current program counter |
| dbg_regs | output | 128 | All eight registers, register n in bits [16n+15:16n] |

## Verification
The assertions and the expected values depend on assumptions about the memory. It must return the word at the address it saw one clock earlier. It must store on the edge where `mem_we` is high. Reads and writes must not interfere within the same cycle.

The bench memory model meets these assumptions exactly. The bench holds reset for several edges before each run. Its test programs keep every address, including effective addresses formed from negative offsets, inside the modelled 256-word range, so no address wraps.

// File: rtl/seqcpu_pkg.sv
package seqcpu_pkg;

    localparam int XLEN   = 16;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);
    localparam int OPC_W  = 4;
    localparam int NOPS   = 1 << OPC_W;
    localparam int MOFF_W = 6;
    localparam int BOFF_W = 12;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;
    typedef logic [OPC_W-1:0]  opc_t;

    localparam opc_t OPC_BRANCH = 4'b0000;
    localparam opc_t OPC_ADD    = 4'b0001;
    localparam opc_t OPC_LOAD   = 4'b0110;
    localparam opc_t OPC_STORE  = 4'b0111;
    localparam opc_t OPC_HALT   = 4'b1111;

    typedef enum logic [3:0] {
        S_FETCH_MAR,
        S_FETCH_RD,
        S_FETCH_MDR,
        S_FETCH_IR,
        S_DECODE,
        S_EVAL,
        S_OPS_MAR,
        S_OPS_RD,
        S_OPS_MDR,
        S_EXEC,
        S_STORE,
        S_HALT
    } phase_e;

    typedef struct packed {
        logic [NOPS-1:0] sel;
        ridx_t           rd;
        ridx_t           ra;
        ridx_t           rb;
        word_t           off_mem;
        word_t           off_br;
    } dec_t;

    function automatic word_t sext_field(input word_t raw, input int unsigned w);
        word_t hi;
        hi = '1 << w;
        return raw[w-1] ? (raw | hi) : (raw & ~hi);
    endfunction

endpackage

// File: rtl/seqcpu_decoder.sv
module seqcpu_decoder
    import seqcpu_pkg::*;
(
    input  word_t instr,
    output dec_t  dec
);

    logic [NOPS-1:0] sel;

    for (genvar g = 0; g < NOPS; g++) begin : g_sel
        assign sel[g] = (instr[XLEN-1 -: OPC_W] == opc_t'(g));
    end

    always_comb begin
        dec         = '0;
        dec.sel     = sel;
        dec.rd      = instr[11:9];
        dec.ra      = instr[8:6];
        dec.rb      = instr[2:0];
        dec.off_mem = sext_field(instr, MOFF_W);
        dec.off_br  = sext_field(instr, BOFF_W);
    end

endmodule

// File: rtl/seqcpu_regfile.sv
module seqcpu_regfile #(
    parameter int NUM   = 8,
    parameter int W     = 16,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [W-1:0]     rdata_a,
    output logic [W-1:0]     rdata_b,
    output logic [NUM*W-1:0] dbg_flat
);

    logic [NUM-1:0][W-1:0] rf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_q <= '0;
        end else begin
            for (int i = 0; i < NUM; i++) begin
                if (we && waddr == IDX_W'(i)) rf_q[i] <= wdata;
            end
        end
    end

    assign rdata_a = rf_q[raddr_a];
    assign rdata_b = rf_q[raddr_b];

    for (genvar g = 0; g < NUM; g++) begin : g_dbg
        assign dbg_flat[g*W +: W] = rf_q[g];
    end

    // R4 / R5: a commanded write is visible in the addressed register next cycle
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        we |=> rf_q[$past(waddr)] == $past(wdata));

    // R8 / R9: without a write the whole file holds its contents
    p_no_spurious_write_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(rf_q));

endmodule

// File: rtl/seqcpu_phase_fsm.sv
module seqcpu_phase_fsm
    import seqcpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   is_load,
    input  logic   is_halt,
    output phase_e phase
);

    phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            S_FETCH_MAR: phase_d = S_FETCH_RD;
            S_FETCH_RD:  phase_d = S_FETCH_MDR;
            S_FETCH_MDR: phase_d = S_FETCH_IR;
            S_FETCH_IR:  phase_d = S_DECODE;
            S_DECODE:    phase_d = S_EVAL;
            S_EVAL:      phase_d = S_OPS_MAR;
            S_OPS_MAR:   phase_d = is_load ? S_OPS_RD : S_EXEC;
            S_OPS_RD:    phase_d = S_OPS_MDR;
            S_OPS_MDR:   phase_d = S_EXEC;
            S_EXEC:      phase_d = S_STORE;
            S_STORE:     phase_d = is_halt ? S_HALT : S_FETCH_MAR;
            S_HALT:      phase_d = S_HALT;
            default:     phase_d = S_FETCH_MAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= S_FETCH_MAR;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R2: decode is always entered straight from the instruction-register load
    p_decode_after_ir_r2: assert property (@(posedge clk) disable iff (rst)
        $changed(phase_q) && phase_q == S_DECODE |-> $past(phase_q) == S_FETCH_IR);

    // R2: the memory read of the operand phase only happens for loads
    p_operand_read_load_r2: assert property (@(posedge clk) disable iff (rst)
        phase_q == S_OPS_RD |-> is_load);

    // R8: the halted phase is never left without reset
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        phase_q == S_HALT |=> phase_q == S_HALT);

endmodule

// File: rtl/seqcpu_core.sv
module seqcpu_core
    import seqcpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [15:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              mem_we,
    input  logic [15:0]       mem_rdata,
    output logic              halted,
    output logic [15:0]       dbg_pc,
    output logic [NREG*XLEN-1:0] dbg_regs
);

    phase_e phase;
    dec_t   dec;

    word_t pc_q, mar_q, mdr_q, ir_q;
    word_t opa_q, opb_q, ea_q, res_q;
    word_t rd_a, rd_b;

    logic is_add, is_load, is_store, is_branch, is_halt;
    logic rf_we;
    ridx_t rf_rb_sel;

    seqcpu_decoder i_decoder (
        .instr (ir_q),
        .dec   (dec)
    );

    assign is_add    = dec.sel[OPC_ADD];
    assign is_load   = dec.sel[OPC_LOAD];
    assign is_store  = dec.sel[OPC_STORE];
    assign is_branch = dec.sel[OPC_BRANCH];
    assign is_halt   = dec.sel[OPC_HALT];

    logic unused_sel;
    assign unused_sel = ^dec.sel;

    seqcpu_phase_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .is_load (is_load),
        .is_halt (is_halt),
        .phase   (phase)
    );

    assign rf_rb_sel = is_store ? dec.rd : dec.rb;
    assign rf_we     = (phase == S_STORE) && (is_add || is_load);

    seqcpu_regfile #(
        .NUM (NREG),
        .W   (XLEN)
    ) i_regfile (
        .clk      (clk),
        .rst      (rst),
        .we       (rf_we),
        .waddr    (dec.rd),
        .wdata    (res_q),
        .raddr_a  (dec.ra),
        .raddr_b  (rf_rb_sel),
        .rdata_a  (rd_a),
        .rdata_b  (rd_b),
        .dbg_flat (dbg_regs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
            ea_q  <= '0;
            res_q <= '0;
        end else begin
            case (phase)
                S_FETCH_MAR: begin
                    mar_q <= pc_q;
                    pc_q  <= pc_q + word_t'(1);
                end
                S_FETCH_MDR: mdr_q <= mem_rdata;
                S_FETCH_IR:  ir_q  <= mdr_q;
                S_DECODE: begin
                    opa_q <= rd_a;
                    opb_q <= rd_b;
                end
                S_EVAL: begin
                    if (is_branch) ea_q <= pc_q + dec.off_br;
                    else           ea_q <= opa_q + dec.off_mem;
                end
                S_OPS_MAR: begin
                    if (is_load || is_store) mar_q <= ea_q;
                    if (is_store)            mdr_q <= opb_q;
                end
                S_OPS_MDR: mdr_q <= mem_rdata;
                S_EXEC: begin
                    if (is_add) res_q <= opa_q + opb_q;
                    else        res_q <= mdr_q;
                end
                S_STORE: begin
                    if (is_branch) pc_q <= ea_q;
                end
                default: ;
            endcase
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign mem_we    = (phase == S_EXEC) && is_store;
    assign halted    = (phase == S_HALT);
    assign dbg_pc    = pc_q;

    // R3: the fetch step advances the PC by exactly one word
    p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
        phase == S_FETCH_MAR |=> pc_q == $past(pc_q) + word_t'(1));

    // R2: the instruction register takes the fetched word from the data register
    p_ir_from_mdr_r2: assert property (@(posedge clk) disable iff (rst)
        phase == S_FETCH_IR |=> ir_q == $past(mdr_q));

    // R6: a write is issued right after the address phase, to the computed address
    p_store_after_mar_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(phase) == S_OPS_MAR && mem_addr == $past(ea_q));

    // R8: once halted, the PC is frozen and memory is never written
    p_halt_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc_q) && !mem_we);

    // R1: the first cycle after reset fetches from address zero
    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> pc_q == '0 && !halted);

endmodule

// File: tb/test_seqcpu_core.sv
module test_seqcpu_core;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  mem_addr, mem_wdata, mem_rdata;
    logic         mem_we, halted;
    logic [15:0]  dbg_pc;
    logic [127:0] dbg_regs;

    always #10 clk = ~clk;

    seqcpu_core i_seqcpu_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .dbg_pc    (dbg_pc),
        .dbg_regs  (dbg_regs)
    );

    logic [15:0] mem [0:255];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [15:0] key;
        logic [15:0] val;
        string       req;
    } item_t;

    item_t exp_mem[$];
    item_t exp_reg[$];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_mem(input logic [15:0] a, input logic [15:0] d, input string req);
        item_t it;
        it.key = a; it.val = d; it.req = req;
        exp_mem.push_back(it);
    endtask

    task automatic push_reg(input int idx, input logic [15:0] d, input string req);
        item_t it;
        it.key = 16'(idx); it.val = d; it.req = req;
        exp_reg.push_back(it);
    endtask

    function automatic logic [15:0] enc_add(int d, int a, int b);
        return 16'h1000 | 16'(d << 9) | 16'(a << 6) | 16'(b);
    endfunction
    function automatic logic [15:0] enc_ld(int d, int b, int off);
        return 16'h6000 | 16'(d << 9) | 16'(b << 6) | (16'(off) & 16'h003F);
    endfunction
    function automatic logic [15:0] enc_st(int s, int b, int off);
        return 16'h7000 | 16'(s << 9) | 16'(b << 6) | (16'(off) & 16'h003F);
    endfunction
    function automatic logic [15:0] enc_br(int off);
        return 16'(off) & 16'h0FFF;
    endfunction

    // Monitor: compares memory writes and register changes against the scoreboard queues
    logic [127:0] prev_regs;
    always @(negedge clk) begin
        if (rst) begin
            prev_regs = dbg_regs;
        end else begin
            if (mem_we) begin
                if (exp_mem.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R6 unexpected write actual=%h:%h expected=none", mem_addr, mem_wdata);
                end else begin
                    item_t it;
                    it = exp_mem.pop_front();
                    chk(it.req, "store address", 32'(mem_addr), 32'(it.key));
                    chk(it.req, "store data", 32'(mem_wdata), 32'(it.val));
                end
            end
            for (int i = 0; i < 8; i++) begin
                if (dbg_regs[i*16 +: 16] !== prev_regs[i*16 +: 16]) begin
                    if (exp_reg.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R9 unexpected write to reg %0d actual=%h expected=%h",
                                 i, dbg_regs[i*16 +: 16], prev_regs[i*16 +: 16]);
                    end else begin
                        item_t it;
                        it = exp_reg.pop_front();
                        chk(it.req, "reg index", 32'(i), 32'(it.key));
                        chk(it.req, "reg value", 32'(dbg_regs[i*16 +: 16]), 32'(it.val));
                    end
                end
            end
            prev_regs = dbg_regs;
        end
    end

    task automatic run_to_halt(output int cyc);
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++; fails++;
        $display("FAIL R2 watchdog expired actual=running expected=halted");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        logic [127:0] snap;
        logic [15:0]  pc_snap;

        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[20] = 16'h1234;
        mem[21] = 16'hFFFF;
        mem[22] = 16'h8001;
        mem[23] = 16'h0007;
        mem[0]  = enc_ld(1, 0, 20);
        mem[1]  = enc_ld(2, 0, 21);
        mem[2]  = enc_add(3, 1, 2);
        mem[3]  = enc_ld(4, 0, 23);
        mem[4]  = enc_add(5, 4, 4);
        mem[5]  = enc_ld(6, 4, 15);
        mem[6]  = enc_st(3, 4, 20);
        mem[7]  = enc_ld(7, 4, 20);
        mem[8]  = 16'hA123;
        mem[9]  = enc_br(2);
        mem[10] = enc_add(1, 1, 1);
        mem[11] = enc_st(1, 0, 0);
        mem[12] = enc_st(2, 4, -3);
        mem[13] = enc_br(3);
        mem[14] = enc_add(1, 1, 1);
        mem[15] = enc_add(1, 1, 1);
        mem[16] = 16'hF000;
        mem[17] = enc_add(1, 3, 6);
        mem[18] = enc_br(-3);

        push_reg(1, 16'h1234, "R5");
        push_reg(2, 16'hFFFF, "R5");
        push_reg(3, 16'h1233, "R4");
        push_reg(4, 16'h0007, "R5");
        push_reg(5, 16'h000E, "R4");
        push_reg(6, 16'h8001, "R5");
        push_mem(16'd27, 16'h1233, "R6");
        push_reg(7, 16'h1233, "R5");
        push_mem(16'd4, 16'hFFFF, "R6");
        push_reg(1, 16'h9234, "R7");

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset pc", 32'(dbg_pc), 32'h0);
        chk("R1", "reset regs zero", 32'(dbg_regs != 0), 32'h0);
        chk("R1", "reset halted", 32'(halted), 32'h0);
        chk("R1", "reset mem_we", 32'(mem_we), 32'h0);
        rst = 1'b0;

        @(posedge clk);
        @(negedge clk);
        chk("R3", "pc after first fetch step", 32'(dbg_pc), 32'h1);
        chk("R1", "first fetch address", 32'(mem_addr), 32'h0);
        run_to_halt(cyc);
        cyc++;
        chk("R2", "cycles to halt", 32'(cyc), 32'd145);
        chk("R8", "halted", 32'(halted), 32'h1);
        chk("R7", "pc after halt", 32'(dbg_pc), 32'd17);
        chk("R10", "reg1 slice", 32'(dbg_regs[31:16]), 32'h9234);
        chk("R10", "reg7 slice", 32'(dbg_regs[127:112]), 32'h1233);
        chk("R4", "reg3 wrap sum", 32'(dbg_regs[63:48]), 32'h1233);
        chk("R6", "memory word 27", 32'(mem[27]), 32'h1233);
        chk("R6", "memory word 4", 32'(mem[4]), 32'hFFFF);
        chk("R7", "skipped store target untouched", 32'(mem[0]), 32'(enc_ld(1, 0, 20)));
        chk("R4", "register queue drained", 32'(exp_reg.size()), 32'h0);
        chk("R6", "memory queue drained", 32'(exp_mem.size()), 32'h0);

        snap = dbg_regs;
        pc_snap = dbg_pc;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R8", "still halted", 32'(halted), 32'h1);
        chk("R8", "pc frozen", 32'(dbg_pc), 32'(pc_snap));
        chk("R8", "regs frozen", 32'(dbg_regs == snap), 32'h1);

        rst = 1'b1;
        mem[0] = 16'h3FFF;
        mem[1] = 16'hF000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "re-reset regs zero", 32'(dbg_regs != 0), 32'h0);
        chk("R1", "re-reset pc", 32'(dbg_pc), 32'h0);
        chk("R1", "re-reset halted", 32'(halted), 32'h0);
        rst = 1'b0;
        run_to_halt(cyc);
        chk("R9", "no-op then halt cycles", 32'(cyc), 32'd18);
        chk("R9", "regs untouched by no-op", 32'(dbg_regs != 0), 32'h0);
        chk("R3", "pc after two fetches", 32'(dbg_pc), 32'h2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule